// File: doc/BRIEF.md
# Clock Divider Transition Sequencer

This block walks a core clock from its present divide ratio to a requested one among the ratios 1, 2, 4, 6 and 8. It keeps the DRAM refresh settings valid for the whole move. A request is a 3-bit index with a one-cycle start strobe. The block then drives three control fields in a direction-dependent order: the divider mode code, the refresh count and the self-refresh enable. It waits for the PLL to relock after every divider change. Before the clock is slowed out of divide-by-1, it waits for outstanding refreshes to drain.

A move between divide-by-1 and a ratio above 2 is always split into two segments that meet at divide-by-2. Self-refresh is only enabled while the clock runs divided. The refresh count for each ratio is fixed at elaboration from the input clock frequency, so no run-time division is needed.

Top module: `clkdiv_step_seq`

## Requirements
- R1: Index 0..4 selects divisor 1, 2, 4, 6, 8. The divider code output is 3'b000 for /1, 3'b001 for /2, 3'b011 for /4, 3'b010 for /6 and 3'b100 for /8, and it never holds any other value.
- R2: After reset the block sits at /1 with code 3'b000, refresh count equal to the /1 table entry, self-refresh off, and busy, done and error all low.
- R3: The refresh count for divisor d equals floor(CLK_HZ × REFI_NS / (UNIT_CLKS × d × 10^9)), saturated to the 7-bit field.
- R4: A /2 to /1 segment clears self-refresh, then writes the divider code, then updates the refresh count.
- R5: A /1 to /2 segment updates the refresh count first. It then waits at least UNIT_CLKS × (old count + new count) × old divisor cycles before writing the divider code. Self-refresh is set last.
- R6: A move from /1 to /4, /6 or /8, or from any of those to /1, is performed as two segments through /2.
- R7: Any other segment toward a larger divisor updates the refresh count and then writes the divider code within 2 cycles, with no wait.
- R8: Any other segment toward a smaller divisor writes the divider code first and updates the refresh count afterwards. A drain wait applies only if self-refresh is off.
- R9: After every divider code write, no output field changes for at least RELOCK_CYC cycles.
- R10: A request whose index equals the current ratio raises done one cycle later. It changes no output, and busy stays low.
- R11: A request with index 5..7 sets the error flag and changes no output. The flag clears when the next valid request is accepted.
- R12: Busy is high from acceptance until the final step completes. Done is a one-cycle pulse. A start strobe that arrives while busy is ignored.
- R13: Self-refresh enable is never high while the divider code is 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request strobe |
| idx_i | input | 3 | Requested ratio index |
| busy_o | output | 1 | Transition in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request had an illegal index |
| div_code_o | output | 3 | Divider mode code |
| refr_cnt_o | output | 7 | Refresh count field |
| sr_en_o | output | 1 | Self-refresh enable |

## Verification
The bench builds the block with CLK_HZ = 100 MHz, RELOCK_CYC = 16, DRAIN_MARGIN = 8 and UNIT_CLKS = 64. These values give five distinct refresh counts (12, 6, 3, 2, 1), so every refresh update shows up as a visible change at the port. The /1 to /2 drain then lasts about 1,160 cycles, which makes the full drain window measurable in a short run. The vector walk visits every class of segment, including both hop paths through /2, and the bench times the gaps between recorded output events.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int unsigned NUM_RATIOS = 5;

  typedef logic [2:0] ridx_t;
  typedef logic [2:0] dcode_t;

  typedef enum logic [2:0] {
    OP_END,
    OP_SR_CLR,
    OP_SR_SET,
    OP_DIV,
    OP_REF_CHK,
    OP_REF_NOW
  } step_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEG,
    ST_OP,
    ST_WAIT,
    ST_DONE
  } seq_state_e;

  function automatic logic [3:0] div_of(ridx_t i);
    case (i)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd6;
      3'd4:    return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic dcode_t code_of(ridx_t i);
    case (i)
      3'd1:    return 3'b001;
      3'd2:    return 3'b011;
      3'd3:    return 3'b010;
      3'd4:    return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic needs_hop(ridx_t a, ridx_t b);
    return ((a == 3'd0) && (b > 3'd1)) || ((a > 3'd1) && (b == 3'd0));
  endfunction

  // Ordered step list of one segment a -> b, k-th entry.
  function automatic step_op_e seg_op(ridx_t a, ridx_t b, logic [1:0] k);
    step_op_e op;
    op = OP_END;
    if ((a == 3'd1) && (b == 3'd0)) begin
      case (k)
        2'd0:    op = OP_SR_CLR;
        2'd1:    op = OP_DIV;
        2'd2:    op = OP_REF_NOW;
        default: op = OP_END;
      endcase
    end else if ((a == 3'd0) && (b == 3'd1)) begin
      case (k)
        2'd0:    op = OP_REF_CHK;
        2'd1:    op = OP_DIV;
        2'd2:    op = OP_SR_SET;
        default: op = OP_END;
      endcase
    end else if (b > a) begin
      case (k)
        2'd0:    op = OP_REF_NOW;
        2'd1:    op = OP_DIV;
        default: op = OP_END;
      endcase
    end else begin
      case (k)
        2'd0:    op = OP_DIV;
        2'd1:    op = OP_REF_CHK;
        default: op = OP_END;
      endcase
    end
    return op;
  endfunction

endpackage

// File: rtl/clkdiv_rcnt_table.sv
module clkdiv_rcnt_table
  import clkdiv_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 400_000_000,
  parameter int unsigned REFI_NS   = 7800,
  parameter int unsigned UNIT_CLKS = 64,
  parameter int unsigned CNT_W     = 7
) (
  input  ridx_t              rd_idx_i,
  output logic [CNT_W-1:0]   rd_cnt_o,
  output logic [CNT_W-1:0]   base_cnt_o
);

  localparam longint CNT_MAX = (64'd1 << CNT_W) - 64'd1;

  function automatic logic [CNT_W-1:0] calc(int i);
    longint num;
    longint den;
    longint q;
    num = longint'(CLK_HZ) * longint'(REFI_NS);
    den = longint'(UNIT_CLKS) * longint'(div_of(ridx_t'(i))) * 64'd1000000000;
    q   = num / den;
    if (q > CNT_MAX) q = CNT_MAX;
    return CNT_W'(q);
  endfunction

  logic [CNT_W-1:0] tbl [NUM_RATIOS];

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_entry
    localparam logic [CNT_W-1:0] ENTRY = calc(g);
    assign tbl[g] = ENTRY;
  end

  always_comb begin
    rd_cnt_o = '0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (rd_idx_i == ridx_t'(i)) rd_cnt_o = tbl[i];
    end
  end

  assign base_cnt_o = tbl[0];

endmodule

// File: rtl/clkdiv_drain_len.sv
module clkdiv_drain_len #(
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned UNIT_CLKS = 64,
  parameter int unsigned MARGIN    = 4,
  parameter int unsigned WAIT_W    = 20
) (
  input  logic [CNT_W-1:0]  old_cnt_i,
  input  logic [CNT_W-1:0]  new_cnt_i,
  input  logic [3:0]        old_div_i,
  output logic [WAIT_W-1:0] len_o
);

  localparam int unsigned SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] sum;
  logic [31:0]      prod;

  always_comb begin
    sum   = SUM_W'(old_cnt_i) + SUM_W'(new_cnt_i);
    prod  = 32'(sum) * 32'(UNIT_CLKS) * 32'(old_div_i) + 32'(MARGIN);
    len_o = WAIT_W'(prod);
  end

endmodule

// File: rtl/clkdiv_wait_timer.sv
module clkdiv_wait_timer #(
  parameter int unsigned WAIT_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] len_i,
  output logic              active_o
);

  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = len_i;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);

  // R9: a new wait is only started once the previous one has run out
  assert_load_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !active_o);

endmodule

// File: rtl/clkdiv_step_seq.sv
module clkdiv_step_seq
  import clkdiv_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 400_000_000,
  parameter int unsigned REFI_NS      = 7800,
  parameter int unsigned UNIT_CLKS    = 64,
  parameter int unsigned CNT_W        = 7,
  parameter int unsigned RELOCK_CYC   = 16,
  parameter int unsigned DRAIN_MARGIN = 4,
  parameter int unsigned WAIT_W       = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       idx_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [2:0]       div_code_o,
  output logic [CNT_W-1:0] refr_cnt_o,
  output logic             sr_en_o
);

  localparam logic [WAIT_W-1:0] RELOCK_LEN = WAIT_W'(RELOCK_CYC);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  // state
  seq_state_e       state_q, state_d;
  ridx_t            cur_q, cur_d;
  ridx_t            tgt_q, tgt_d;
  ridx_t            seg_a_q, seg_a_d;
  ridx_t            seg_b_q, seg_b_d;
  logic [1:0]       step_q, step_d;
  dcode_t           code_q, code_d;
  logic [CNT_W-1:0] rcnt_q, rcnt_d;
  logic             sr_q, sr_d;
  logic             err_q, err_d;

  // helpers
  logic [CNT_W-1:0]  tbl_cnt, base_cnt;
  logic [WAIT_W-1:0] drain_len;
  logic              tmr_load, tmr_active;
  logic [WAIT_W-1:0] tmr_len;
  step_op_e          op;

  clkdiv_rcnt_table #(
    .CLK_HZ(CLK_HZ), .REFI_NS(REFI_NS), .UNIT_CLKS(UNIT_CLKS), .CNT_W(CNT_W)
  ) u_table (
    .rd_idx_i  (seg_b_q),
    .rd_cnt_o  (tbl_cnt),
    .base_cnt_o(base_cnt)
  );

  clkdiv_drain_len #(
    .CNT_W(CNT_W), .UNIT_CLKS(UNIT_CLKS), .MARGIN(DRAIN_MARGIN), .WAIT_W(WAIT_W)
  ) u_drain (
    .old_cnt_i(rcnt_q),
    .new_cnt_i(tbl_cnt),
    .old_div_i(div_of(seg_a_q)),
    .len_o    (drain_len)
  );

  clkdiv_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .load_i  (tmr_load),
    .len_i   (tmr_len),
    .active_o(tmr_active)
  );

  assign op = seg_op(seg_a_q, seg_b_q, step_q);

  // next state
  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    tgt_d    = tgt_q;
    seg_a_d  = seg_a_q;
    seg_b_d  = seg_b_q;
    step_d   = step_q;
    code_d   = code_q;
    rcnt_d   = rcnt_q;
    sr_d     = sr_q;
    err_d    = err_q;
    tmr_load = 1'b0;
    tmr_len  = RELOCK_LEN;

    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (idx_i >= 3'(NUM_RATIOS)) begin
            err_d = 1'b1;
          end else begin
            err_d = 1'b0;
            if (idx_i == cur_q) begin
              state_d = ST_DONE;
            end else begin
              tgt_d   = idx_i;
              state_d = ST_SEG;
            end
          end
        end
      end

      ST_SEG: begin
        seg_a_d = cur_q;
        seg_b_d = needs_hop(cur_q, tgt_q) ? 3'd1 : tgt_q;
        step_d  = 2'd0;
        state_d = ST_OP;
      end

      ST_OP: begin
        step_d = step_q + 2'd1;
        case (op)
          OP_SR_CLR: sr_d = 1'b0;
          OP_SR_SET: sr_d = 1'b1;
          OP_DIV: begin
            code_d   = code_of(seg_b_q);
            cur_d    = seg_b_q;
            tmr_load = 1'b1;
            tmr_len  = RELOCK_LEN;
            state_d  = ST_WAIT;
          end
          OP_REF_CHK: begin
            rcnt_d = tbl_cnt;
            if (!sr_q) begin
              tmr_load = 1'b1;
              tmr_len  = drain_len;
              state_d  = ST_WAIT;
            end
          end
          OP_REF_NOW: rcnt_d = tbl_cnt;
          default: begin
            step_d  = step_q;
            state_d = (cur_q == tgt_q) ? ST_DONE : ST_SEG;
          end
        endcase
      end

      ST_WAIT: begin
        if (!tmr_active) state_d = ST_OP;
      end

      ST_DONE: state_d = ST_IDLE;

      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      cur_q   <= 3'd0;
      tgt_q   <= 3'd0;
      seg_a_q <= 3'd0;
      seg_b_q <= 3'd0;
      step_q  <= 2'd0;
      code_q  <= 3'b000;
      rcnt_q  <= base_cnt;
      sr_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      tgt_q   <= tgt_d;
      seg_a_q <= seg_a_d;
      seg_b_q <= seg_b_d;
      step_q  <= step_d;
      code_q  <= code_d;
      rcnt_q  <= rcnt_d;
      sr_q    <= sr_d;
      err_q   <= err_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o     = (state_q == ST_DONE);
  assign err_o      = err_q;
  assign div_code_o = code_q;
  assign refr_cnt_o = rcnt_q;
  assign sr_en_o    = sr_q;

  // R1: only the five legal mode codes ever appear
  assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (div_code_o == 3'b000) || (div_code_o == 3'b001) || (div_code_o == 3'b011) ||
    (div_code_o == 3'b010) || (div_code_o == 3'b100));

  // R9: the relock timer is running in the cycle a new code appears
  assert_relock_start_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (div_code_o != $past(div_code_o)) |-> tmr_active);

  // R13: self-refresh only while divided
  assert_sr_divided_R13: assert property (@(posedge clk) disable iff (!rst_q_n)
    sr_en_o |-> (div_code_o != 3'b000));

  // R12: done lasts one cycle
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_o |=> !done_o);

  // R10 / R12: fields only move under busy
  assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    !busy_o |=> ($stable(div_code_o) && $stable(refr_cnt_o) && $stable(sr_en_o)));

endmodule

// File: tb/sim_clkdiv_step_seq.sv
module sim_clkdiv_step_seq;

  localparam int unsigned TB_CLK_HZ = 100_000_000;
  localparam int unsigned TB_RELOCK = 16;
  localparam int unsigned TB_UNIT   = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [2:0] idx_i;
  logic       busy_o, done_o, err_o, sr_en_o;
  logic [2:0] div_code_o;
  logic [6:0] refr_cnt_o;

  always #5 clk = ~clk;

  clkdiv_step_seq #(
    .CLK_HZ(TB_CLK_HZ), .REFI_NS(7800), .UNIT_CLKS(TB_UNIT), .CNT_W(7),
    .RELOCK_CYC(TB_RELOCK), .DRAIN_MARGIN(8), .WAIT_W(20)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .idx_i(idx_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .div_code_o(div_code_o), .refr_cnt_o(refr_cnt_o), .sr_en_o(sr_en_o)
  );

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // expected values from the requirements
  function automatic logic [2:0] exp_code(int i);
    case (i)
      1: return 3'b001;
      2: return 3'b011;
      3: return 3'b010;
      4: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int exp_div(int i);
    case (i)
      1: return 2;
      2: return 4;
      3: return 6;
      4: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_rc(int i);
    longint q;
    q = (longint'(TB_CLK_HZ) * 64'd7800) / (longint'(TB_UNIT) * longint'(exp_div(i)) * 64'd1000000000);
    return int'(q);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // event log: 1 = self-refresh cleared, 2 = set, 3 = divider, 4 = refresh count
  bit         mon_en = 1'b0;
  int         ev_n = 0;
  int         ev_t   [256];
  logic [2:0] ev_k   [256];
  int         ev_old [256];
  int         ev_new [256];
  logic       ev_psr [256];
  logic [2:0] p_code;
  logic [6:0] p_rc;
  logic       p_sr;

  always @(negedge clk) begin
    if (mon_en && ev_n < 250) begin
      if (sr_en_o != p_sr) begin
        ev_k[ev_n] = sr_en_o ? 3'd2 : 3'd1; ev_t[ev_n] = cyc; ev_psr[ev_n] = p_sr;
        ev_old[ev_n] = 0; ev_new[ev_n] = 0; ev_n = ev_n + 1;
      end
      if (div_code_o != p_code) begin
        ev_k[ev_n] = 3'd3; ev_t[ev_n] = cyc; ev_psr[ev_n] = p_sr;
        ev_old[ev_n] = 0; ev_new[ev_n] = 0; ev_n = ev_n + 1;
      end
      if (refr_cnt_o != p_rc) begin
        ev_k[ev_n] = 3'd4; ev_t[ev_n] = cyc; ev_psr[ev_n] = p_sr;
        ev_old[ev_n] = int'(p_rc); ev_new[ev_n] = int'(refr_cnt_o); ev_n = ev_n + 1;
      end
    end
    p_code = div_code_o;
    p_rc   = refr_cnt_o;
    p_sr   = sr_en_o;
  end

  // vector: idx[23:21], event count[20:18], events[17:0] (first in [2:0])
  localparam int NVEC = 11;
  localparam logic [23:0] VEC [NVEC] = '{
    {3'd1, 3'd3, 18'o000234},  // R5 /1->/2
    {3'd0, 3'd3, 18'o000431},  // R4 /2->/1
    {3'd2, 3'd5, 18'o034234},  // R6 /1->/4 via /2
    {3'd4, 3'd2, 18'o000034},  // R7 /4->/8
    {3'd3, 3'd2, 18'o000043},  // R8 /8->/6
    {3'd0, 3'd5, 18'o043143},  // R6 /6->/1 via /2
    {3'd3, 3'd5, 18'o034234},  // R6 /1->/6 via /2
    {3'd1, 3'd2, 18'o000043},  // R8 /6->/2
    {3'd2, 3'd2, 18'o000034},  // R7 /2->/4
    {3'd4, 3'd2, 18'o000034},  // R7 /4->/8
    {3'd0, 3'd5, 18'o043143}   // R6 /8->/1 via /2
  };

  task automatic go(input int idx);
    @(negedge clk);
    start_i = 1'b1;
    idx_i   = 3'(idx);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (done_o) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic check_final(input int idx, input string req);
    chk(div_code_o == exp_code(idx), req, "final divider code", int'(div_code_o), int'(exp_code(idx)));
    chk(int'(refr_cnt_o) == exp_rc(idx), "R3", "final refresh count", int'(refr_cnt_o), exp_rc(idx));
    chk(sr_en_o == (idx != 0), "R13", "final self-refresh", int'(sr_en_o), int'(idx != 0));
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    bit seen;
    int base;
    start_i = 1'b0;
    idx_i   = 3'd0;
    rst_n   = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 reset state
    chk(div_code_o == 3'b000, "R2", "reset code", int'(div_code_o), 0);
    chk(int'(refr_cnt_o) == exp_rc(0), "R2", "reset refresh count", int'(refr_cnt_o), exp_rc(0));
    chk(!sr_en_o && !busy_o && !done_o && !err_o, "R2", "reset flags",
        int'({sr_en_o, busy_o, done_o, err_o}), 0);
    mon_en = 1'b1;

    // vector walk
    for (int v = 0; v < NVEC; v++) begin
      int idx;
      int nev;
      idx  = int'(VEC[v][23:21]);
      nev  = int'(VEC[v][20:18]);
      base = ev_n;
      go(idx);
      chk(busy_o, "R12", "busy after accept", int'(busy_o), 1);
      wait_done(seen);
      chk(seen, "R12", "done reached", int'(seen), 1);
      chk(!busy_o, "R12", "busy low at done", int'(busy_o), 0);
      check_final(idx, "R1");
      chk(ev_n - base == nev, "R4/R5/R6/R7/R8", "event count", ev_n - base, nev);
      for (int e = 0; e < nev && base + e < ev_n; e++) begin
        int ek;
        ek = int'(VEC[v][3*e +: 3]);
        chk(int'(ev_k[base+e]) == ek, "R4/R5/R6/R7/R8", "event order", int'(ev_k[base+e]), ek);
      end
      for (int e = base; e < ev_n - 1; e++) begin
        int g;
        g = ev_t[e+1] - ev_t[e];
        if (ev_k[e] == 3'd3)
          chk(g >= int'(TB_RELOCK), "R9", "relock gap", g, int'(TB_RELOCK));
        if (ev_k[e] == 3'd4 && ev_k[e+1] == 3'd3) begin
          if (!ev_psr[e])
            chk(g >= int'(TB_UNIT) * (ev_old[e] + ev_new[e]), "R5", "drain gap",
                g, int'(TB_UNIT) * (ev_old[e] + ev_new[e]));
          else
            chk(g <= 2, "R7", "no-wait gap", g, 2);
        end
      end
      @(negedge clk);
      chk(!done_o, "R12", "done one cycle", int'(done_o), 0);
    end

    // R10 same ratio (now at /1)
    base = ev_n;
    go(0);
    chk(done_o && !busy_o, "R10", "immediate done", int'({done_o, busy_o}), 2);
    @(negedge clk);
    chk(!done_o, "R10", "done drops", int'(done_o), 0);
    chk(ev_n == base, "R10", "no field change", ev_n - base, 0);

    // R11 illegal indices
    go(5);
    chk(err_o && !done_o && !busy_o, "R11", "error flag idx5", int'({err_o, done_o, busy_o}), 4);
    go(7);
    repeat (5) @(negedge clk);
    chk(err_o, "R11", "error flag idx7", int'(err_o), 1);
    chk(ev_n == base && !busy_o, "R11", "illegal ignored", ev_n - base, 0);
    check_final(0, "R11");

    // R12 start while busy ignored; R11 error cleared by accepted request
    go(1);
    chk(!err_o, "R11", "error cleared", int'(err_o), 0);
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    idx_i   = 3'd4;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R12", "still busy", int'(busy_o), 1);
    wait_done(seen);
    chk(seen, "R12", "done after ignored start", int'(seen), 1);
    check_final(1, "R12");
    repeat (3) @(negedge clk);
    chk(!busy_o && div_code_o == 3'b001, "R12", "late start dropped", int'(div_code_o), 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule